// File: doc/BRIEF.md
# Pipelined Bitonic Record Sorter

This block sorts a set of N records each clock cycle with a bitonic compare-and-swap network. It has a register after every compare step. Each record has two fields of equal width: a key and a data word. Only the key takes part in the comparisons. The data word travels with its key to whatever position the key reaches.

A direction bit comes in with each set and chooses the order of the result:
- 0 sorts the set descending, with the largest key at position 0.
- 1 sorts the set ascending.

The direction bit and a valid flag move through the pipeline beside the records. Each set is therefore sorted in the mode it arrived with, even when the modes change from one cycle to the next.

The latency is fixed and does not depend on the data, so a scheduler can plan around it. For N inputs it is log2(N)·(log2(N)+1)/2 cycles, which is 6 cycles for N = 8. Every step holds N/2 cells, which makes 24 cells for N = 8. The longest combinational path is a single cell: one comparator, one XOR with the mode, and a 2:1 mux for each field.

Top module: `bitonic_sorter`

## Requirements
- R1: With direction 0, the output keys do not increase from position 0 to position N-1. Record i sits in bits [i*FIELD_W +: FIELD_W] of each key and data bus.
- R2: With direction 1, the output keys do not decrease from position 0 to position N-1.
- R3: The output set holds exactly the input (key, data) pairs, as a multiset. A data word always leaves beside the key it entered with.
- R4: A set presented with in_vld high appears with out_vld high exactly log2(N)·(log2(N)+1)/2 cycles later (6 for N=8). A cycle with in_vld low gives a cycle with out_vld low at the same distance.
- R5: A new set is accepted on every clock with no stall, so back-to-back sets come out on back-to-back cycles.
- R6: out_dir equals the direction given with the set that is leaving, and that set is ordered in that direction, even when consecutive sets alternate.
- R7: Two records with equal keys are never exchanged. If all N keys of a set are equal, every record leaves at the position it entered.
- R8: While rst is high at a clock edge, the pipeline clears, so out_vld, out_dir and all output fields read 0. No set that was in flight before the reset comes out afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | The input set is valid this cycle |
| in_dir | input | 1 | Sort order for this set: 0 descending, 1 ascending |
| in_key | input | N*FIELD_W | Keys of the N input records |
| in_dat | input | N*FIELD_W | Data words of the N input records |
| out_vld | output | 1 | The output set is valid |
| out_dir | output | 1 | Sort order the output set was sorted in |
| out_key | output | N*FIELD_W | Sorted keys |
| out_dat | output | N*FIELD_W | Data words, aligned with out_key |

## Verification
The bench uses these input patterns:
- **Wide-range random keys.** These exercise general ordering in both directions.
- **Random keys from only four values.** These create many ties, which separates correct pairing of data to keys from mere key ordering.
- **Presorted and reverse-sorted sets.** These expose a cell whose mode is inverted or a stage whose alternation is wrong.
- **Sets whose keys are all equal, with distinct data.** These catch any swap on equality, because the data order must stay unchanged.
- **Streams whose direction alternates every cycle, with random gaps.** These show whether the direction stays with its own set and whether the valid timing holds at exactly the stated latency.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    typedef enum logic {
        ORD_DESC = 1'b0,
        ORD_ASC  = 1'b1
    } sort_ord_e;

    // Number of compare steps in stages 0 .. lg-1 of a bitonic network.
    function automatic int step_count(input int lg);
        return (lg * (lg + 1)) / 2;
    endfunction

    // Lower record index of compare pair p in a step with distance 2**dlog.
    function automatic int pair_lo(input int p, input int dlog);
        return ((p >> dlog) << (dlog + 1)) | (p & ((1 << dlog) - 1));
    endfunction

    // Mode inversion for a cell of a given stage: alternates per block of
    // 2**(stage+1) records; zero for every cell of the final stage.
    function automatic bit stage_flip(input int lo, input int stage);
        return bit'((lo >> (stage + 1)) & 1);
    endfunction

endpackage

// File: rtl/bsort_cell.sv
module bsort_cell
    import bsort_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  sort_ord_e            mode,
    input  logic [FIELD_W-1:0]   a_key,
    input  logic [FIELD_W-1:0]   a_dat,
    input  logic [FIELD_W-1:0]   b_key,
    input  logic [FIELD_W-1:0]   b_dat,
    output logic [FIELD_W-1:0]   x_key,
    output logic [FIELD_W-1:0]   x_dat,
    output logic [FIELD_W-1:0]   y_key,
    output logic [FIELD_W-1:0]   y_dat
);
    logic a_less;
    logic keys_differ;
    logic swap;

    // Mode 0 keeps the larger key on the lower port; mode 1 inverts the
    // decision through a single XOR. Equal keys never exchange.
    assign a_less      = (a_key < b_key);
    assign keys_differ = (a_key != b_key);
    assign swap        = keys_differ & (a_less ^ (mode == ORD_ASC));

    assign x_key = swap ? b_key : a_key;
    assign x_dat = swap ? b_dat : a_dat;
    assign y_key = swap ? a_key : b_key;
    assign y_dat = swap ? a_dat : b_dat;

endmodule

// File: rtl/bsort_step.sv
module bsort_step
    import bsort_pkg::*;
#(
    parameter int N       = 8,
    parameter int FIELD_W = 8,
    parameter int STAGE   = 0,
    parameter int DLOG    = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic                 in_dir,
    input  logic [N*FIELD_W-1:0] in_key,
    input  logic [N*FIELD_W-1:0] in_dat,
    output logic                 out_vld,
    output logic                 out_dir,
    output logic [N*FIELD_W-1:0] out_key,
    output logic [N*FIELD_W-1:0] out_dat
);
    localparam int LG    = $clog2(N);
    localparam int PAIRS = N / 2;
    localparam int DIST  = 1 << DLOG;
    localparam int SW    = FIELD_W + LG;

    logic [N*FIELD_W-1:0] nx_key;
    logic [N*FIELD_W-1:0] nx_dat;

    for (genvar gp = 0; gp < PAIRS; gp++) begin : g_pair
        localparam int  LO   = pair_lo(gp, DLOG);
        localparam int  HI   = LO + DIST;
        localparam bit  FLIP = stage_flip(LO, STAGE);

        sort_ord_e cell_mode;
        assign cell_mode = sort_ord_e'(in_dir ^ FLIP);

        bsort_cell #(.FIELD_W(FIELD_W)) u_cell (
            .mode  (cell_mode),
            .a_key (in_key[LO*FIELD_W +: FIELD_W]),
            .a_dat (in_dat[LO*FIELD_W +: FIELD_W]),
            .b_key (in_key[HI*FIELD_W +: FIELD_W]),
            .b_dat (in_dat[HI*FIELD_W +: FIELD_W]),
            .x_key (nx_key[LO*FIELD_W +: FIELD_W]),
            .x_dat (nx_dat[LO*FIELD_W +: FIELD_W]),
            .y_key (nx_key[HI*FIELD_W +: FIELD_W]),
            .y_dat (nx_dat[HI*FIELD_W +: FIELD_W])
        );

        // R1/R2 at cell level: each registered pair is ordered per its mode.
        p_cell_order_r1: assert property (@(posedge clk) disable iff (rst)
            out_vld |->
                ((out_dir ^ FLIP)
                    ? (out_key[LO*FIELD_W +: FIELD_W] <= out_key[HI*FIELD_W +: FIELD_W])
                    : (out_key[LO*FIELD_W +: FIELD_W] >= out_key[HI*FIELD_W +: FIELD_W])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_dir <= 1'b0;
            out_key <= '0;
            out_dat <= '0;
        end else begin
            out_vld <= in_vld;
            out_dir <= in_dir;
            out_key <= nx_key;
            out_dat <= nx_dat;
        end
    end

    // R3: a step only permutes records, so the key total is conserved.
    logic [SW-1:0] sum_in;
    logic [SW-1:0] sum_out;
    always_comb begin
        sum_in  = '0;
        sum_out = '0;
        for (int i = 0; i < N; i++) begin
            sum_in  = sum_in  + SW'(in_key[i*FIELD_W +: FIELD_W]);
            sum_out = sum_out + SW'(out_key[i*FIELD_W +: FIELD_W]);
        end
    end

    p_key_sum_r3: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (sum_out == $past(sum_in)));

endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter
    import bsort_pkg::*;
#(
    parameter int N       = 8,
    parameter int FIELD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic                 in_dir,
    input  logic [N*FIELD_W-1:0] in_key,
    input  logic [N*FIELD_W-1:0] in_dat,
    output logic                 out_vld,
    output logic                 out_dir,
    output logic [N*FIELD_W-1:0] out_key,
    output logic [N*FIELD_W-1:0] out_dat
);
    localparam int LG    = $clog2(N);
    localparam int STEPS = step_count(LG);
    localparam int CW    = $clog2(STEPS + 2);

    logic [N*FIELD_W-1:0] p_key [0:STEPS];
    logic [N*FIELD_W-1:0] p_dat [0:STEPS];
    logic                 p_vld [0:STEPS];
    logic                 p_dir [0:STEPS];

    assign p_key[0] = in_key;
    assign p_dat[0] = in_dat;
    assign p_vld[0] = in_vld;
    assign p_dir[0] = in_dir;

    for (genvar gs = 0; gs < LG; gs++) begin : g_stage
        for (genvar gu = 0; gu <= gs; gu++) begin : g_step
            localparam int IDX = step_count(gs) + gu;
            bsort_step #(
                .N       (N),
                .FIELD_W (FIELD_W),
                .STAGE   (gs),
                .DLOG    (gs - gu)
            ) u_step (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (p_vld[IDX]),
                .in_dir  (p_dir[IDX]),
                .in_key  (p_key[IDX]),
                .in_dat  (p_dat[IDX]),
                .out_vld (p_vld[IDX+1]),
                .out_dir (p_dir[IDX+1]),
                .out_key (p_key[IDX+1]),
                .out_dat (p_dat[IDX+1])
            );
        end
    end

    assign out_vld = p_vld[STEPS];
    assign out_dir = p_dir[STEPS];
    assign out_key = p_key[STEPS];
    assign out_dat = p_dat[STEPS];

    // Adjacent output positions are ordered per the set's direction.
    for (genvar gi = 0; gi < N - 1; gi++) begin : g_ord
        p_desc_order_r1: assert property (@(posedge clk) disable iff (rst)
            (out_vld && !out_dir) |->
                (out_key[gi*FIELD_W +: FIELD_W] >= out_key[(gi+1)*FIELD_W +: FIELD_W]));
        p_asc_order_r2: assert property (@(posedge clk) disable iff (rst)
            (out_vld && out_dir) |->
                (out_key[gi*FIELD_W +: FIELD_W] <= out_key[(gi+1)*FIELD_W +: FIELD_W]));
    end

    // Sets accepted but not yet delivered; never more than the pipe depth.
    logic [CW-1:0] in_flight;
    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= '0;
        end else begin
            case ({in_vld, out_vld})
                2'b10:   in_flight <= in_flight + CW'(1);
                2'b01:   in_flight <= in_flight - CW'(1);
                default: in_flight <= in_flight;
            endcase
        end
    end

    p_no_phantom_r4: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (in_flight != '0));
    p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(in_flight) <= STEPS));

endmodule

// File: tb/bitonic_sorter_test.sv
module bitonic_sorter_test;
    localparam int NB  = 8;
    localparam int WB  = 8;
    localparam int LGB = 3;
    localparam int LAT = (LGB * (LGB + 1)) / 2;   // R4: 6 cycles for N=8
    localparam int BW  = NB * WB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic          in_dir = 1'b0;
    logic [BW-1:0] in_key = '0;
    logic [BW-1:0] in_dat = '0;
    logic          out_vld;
    logic          out_dir;
    logic [BW-1:0] out_key;
    logic [BW-1:0] out_dat;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [BW-1:0] rk  [16];
    logic [BW-1:0] rd  [16];
    bit            rv  [16];
    bit            rdr [16];
    bit            rex [16];

    always #4 clk = ~clk;   // 125 MHz

    bitonic_sorter #(.N(NB), .FIELD_W(WB)) uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dir(in_dir),
        .in_key(in_key), .in_dat(in_dat), .out_vld(out_vld),
        .out_dir(out_dir), .out_key(out_key), .out_dat(out_dat)
    );

    function automatic logic [BW-1:0] ref_sort(input logic [BW-1:0] k, input bit asc);
        logic [WB-1:0] a [NB];
        logic [WB-1:0] t;
        logic [BW-1:0] r;
        for (int i = 0; i < NB; i++) a[i] = k[i*WB +: WB];
        for (int i = 0; i < NB; i++)
            for (int j = 0; j < NB - 1 - i; j++)
                if (asc ? (a[j] > a[j+1]) : (a[j] < a[j+1])) begin
                    t = a[j]; a[j] = a[j+1]; a[j+1] = t;
                end
        for (int i = 0; i < NB; i++) r[i*WB +: WB] = a[i];
        return r;
    endfunction

    function automatic bit pairs_match(input logic [BW-1:0] ki, input logic [BW-1:0] di,
                                       input logic [BW-1:0] ko, input logic [BW-1:0] dout);
        bit used [NB];
        bit found;
        for (int i = 0; i < NB; i++) used[i] = 1'b0;
        for (int o = 0; o < NB; o++) begin
            found = 1'b0;
            for (int i = 0; i < NB; i++)
                if (!found && !used[i] && ki[i*WB +: WB] === ko[o*WB +: WB]
                    && di[i*WB +: WB] === dout[o*WB +: WB]) begin
                    used[i] = 1'b1;
                    found   = 1'b1;
                end
            if (!found) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check_slot(input int slot_cyc);
        int s;
        logic [BW-1:0] ek;
        bit ev;
        s  = slot_cyc & 15;
        ev = (slot_cyc >= 0) ? rv[s] : 1'b0;
        checks++;
        if (out_vld !== ev) begin
            errors++;
            $display("FAIL R4/R5: out_vld=%0b expected %0b (cycle %0d)", out_vld, ev, cyc);
        end
        if (ev && out_vld === 1'b1) begin
            checks++;
            if (out_dir !== rdr[s]) begin
                errors++;
                $display("FAIL R6: out_dir=%0b expected %0b", out_dir, rdr[s]);
            end
            ek = ref_sort(rk[s], rdr[s]);
            checks++;
            if (out_key !== ek) begin
                errors++;
                $display("FAIL %s: keys=%h expected %h", rdr[s] ? "R2" : "R1", out_key, ek);
            end
            checks++;
            if (!pairs_match(rk[s], rd[s], out_key, out_dat)) begin
                errors++;
                $display("FAIL R3: pairs key=%h dat=%h expected from key=%h dat=%h",
                         out_key, out_dat, rk[s], rd[s]);
            end
            if (rex[s]) begin
                checks++;
                if (out_key !== rk[s] || out_dat !== rd[s]) begin
                    errors++;
                    $display("FAIL R7: dat=%h expected %h", out_dat, rd[s]);
                end
            end
        end
    endtask

    task automatic tick(input bit v, input bit d, input bit ex,
                        input logic [BW-1:0] k, input logic [BW-1:0] dd);
        @(negedge clk);
        check_slot(cyc - LAT);
        in_vld = v; in_dir = d; in_key = k; in_dat = dd;
        rv[cyc & 15] = v; rdr[cyc & 15] = d; rex[cyc & 15] = ex;
        rk[cyc & 15] = k; rd[cyc & 15] = dd;
        cyc++;
    endtask

    task automatic check_reset_state();
        checks++;
        if (out_vld !== 1'b0 || out_dir !== 1'b0 || out_key !== '0 || out_dat !== '0) begin
            errors++;
            $display("FAIL R8: vld=%0b dir=%0b key=%h dat=%h expected all zero",
                     out_vld, out_dir, out_key, out_dat);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b0;
        for (int i = 0; i < 16; i++) rv[i] = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        cyc = 0;
    endtask

    function automatic logic [BW-1:0] rand_bus(input int hi);
        logic [BW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*WB +: WB] = WB'($urandom_range(0, hi));
        return r;
    endfunction

    function automatic logic [BW-1:0] ramp(input bit up);
        logic [BW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*WB +: WB] = WB'(up ? i * 30 : 255 - i * 30);
        return r;
    endfunction

    function automatic logic [BW-1:0] ids(input int base);
        logic [BW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*WB +: WB] = WB'(base + i);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 16; i++) rv[i] = 1'b0;
        // R8: reset state
        do_reset();

        // R1/R2: ascending input sorted descending, descending input ascending
        tick(1, 0, 0, ramp(1), ids(16));
        tick(1, 1, 0, ramp(0), ids(32));
        tick(1, 0, 0, ramp(0), ids(48));
        tick(1, 1, 0, ramp(1), ids(64));
        // R7: all keys equal, distinct data, both directions
        tick(1, 0, 1, {NB{8'h5A}}, ids(80));
        tick(1, 1, 1, {NB{8'h5A}}, ids(96));
        // extremes of the key range
        tick(1, 0, 0, {8'h00, 8'hFF, 8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE}, ids(112));
        tick(1, 1, 0, {8'h00, 8'hFF, 8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE}, ids(128));

        // R5/R6: back-to-back sets with alternating direction
        for (int n = 0; n < 24; n++) tick(1, n[0], 0, rand_bus(255), rand_bus(255));

        // R3/R4: random stream with ties and gaps
        for (int n = 0; n < 600; n++) begin
            bit v;
            v = ($urandom_range(0, 7) != 0);
            tick(v, 1'($urandom_range(0, 1)), 0,
                 rand_bus(n[2] ? 3 : 255), rand_bus(255));
        end

        // R8: reset with the pipe full, nothing in flight may emerge
        for (int n = 0; n < LAT; n++) tick(1, 0, 0, rand_bus(255), rand_bus(255));
        do_reset();
        for (int n = 0; n < LAT + 2; n++) tick(0, 0, 0, '0, '0);

        for (int n = 0; n < 40; n++) tick(1, n[1], 0, rand_bus(15), rand_bus(255));
        for (int n = 0; n < LAT + 2; n++) tick(0, 0, 0, '0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule